// File: doc/BRIEF.md
# Multi-Cycle Fetch and Post-Increment Load Sequencer

This block is the control and address side of a small multi-cycle processor. A state machine moves an instruction word from a single-port memory into an instruction register over three cycles, using four registers: a program counter, a memory address register, a memory data register and an instruction register. The program counter is advanced by its own incrementer during the memory read, so it is ready for the next fetch when the read completes.

After the fetch, a decode cycle reads the base register named by the instruction. A decoded-opcode input tells the block whether the instruction is a load with post-increment. If it is not, the instruction ends in the decode cycle. If it is, three more cycles follow. An execute cycle reads memory at the base address and forms base+4 at the same time. A cycle then writes the loaded word to the destination register. A final cycle writes the incremented address back to the base register. The two writes are spread over two cycles because the register file has one write port. The memory and the register file sit outside the block. A state code and a one-cycle completion pulse let a harness count the cycles each instruction takes.

Top module: `fetch_load_seq`

## Requirements
- R1: An active-high synchronous reset sets the program counter to 0 and the state code to 0, and holds the memory read strobe, the register write enable and the completion pulse low.
- R2: The state codes are: 0 address setup, 1 memory read, 2 instruction load, 3 decode, 4 execute, 5 data write-back, 6 base write-back. In state 0 the program counter is copied into the address register, and there is no memory access.
- R3: In state 1 the block asserts the read strobe with the address register on the memory address. It latches the read data into the data register. In the same cycle it loads the program counter with its value plus 4.
- R4: In state 2 the data register is moved into the instruction register, and that value appears on the instruction output from state 3 onwards.
- R5: In state 3 the register read index is instruction bits [25:21]. The block samples the decoded-opcode input there. A load has opcode 6'h23 in bits [31:26]. When the input is low, the instruction completes in state 3, which gives 4 cycles per instruction.
- R6: In state 4 the block asserts the read strobe with the base register value on the memory address, and latches the read data.
- R7: State 5 writes the loaded word to register bits [20:16] of the instruction. State 6 writes the base value plus 4 to register bits [25:21]. A load takes 7 cycles.
- R8: At most one memory read and at most one register write occur in any cycle, and never both together.
- R9: When the base and destination indices are equal, the register ends up holding base+4.
- R10: The completion pulse is high for exactly one cycle, in the last state of each instruction. The next cycle is state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | XLEN | Memory byte address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | XLEN | Memory read data, valid in the strobe cycle |
| rf_raddr | output | RAW | Register-file read index (base field) |
| rf_rdata | input | XLEN | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RAW | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| is_ldpi | input | 1 | Decoded opcode: current instruction is a post-increment load |
| ir_word | output | XLEN | Instruction register contents |
| pc_value | output | XLEN | Program counter |
| state_code | output | 3 | Current sequencer state |
| instr_done | output | 1 | One-cycle instruction completion pulse |

## Verification
The program mixes post-increment loads with non-load words. This separates the 4-cycle path from the 7-cycle path, and it shows that the decoded-opcode input is sampled only in the decode cycle. Two loads use the same base register, so the second one must use the address written back by the first, which exposes a missing or misdirected base write. One load names the same register as base and destination, and the value left there shows which write comes last. A reset in the middle of an instruction checks that the sequencer goes back to the first fetch state with a cleared program counter.

// File: rtl/fls_pkg.sv
package fls_pkg;

  typedef enum logic [2:0] {
    ST_F_ADDR  = 3'd0,
    ST_F_READ  = 3'd1,
    ST_F_IR    = 3'd2,
    ST_DECODE  = 3'd3,
    ST_EXEC    = 3'd4,
    ST_WB_DATA = 3'd5,
    ST_WB_BASE = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_rf;
    logic mdr_load;
    logic pc_load;
    logic ir_load;
    logic inc_load;
    logic mem_rd;
    logic rf_we;
    logic wsel_base;
    logic done;
  } seq_ctl_t;

endpackage

// File: rtl/fls_step.sv
module fls_step #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  assign y = a + W'(STEP);
endmodule

// File: rtl/fls_ctrl.sv
module fls_ctrl
  import fls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       is_ldpi,
  output seq_state_e state,
  output seq_ctl_t   ctl
);
  seq_state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F_ADDR;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = ST_F_ADDR;
    case (state)
      ST_F_ADDR: begin
        ctl.mar_from_pc = 1'b1;
        nxt = ST_F_READ;
      end
      ST_F_READ: begin
        ctl.mem_rd   = 1'b1;
        ctl.mdr_load = 1'b1;
        ctl.pc_load  = 1'b1;
        nxt = ST_F_IR;
      end
      ST_F_IR: begin
        ctl.ir_load = 1'b1;
        nxt = ST_DECODE;
      end
      ST_DECODE: begin
        if (is_ldpi) begin
          ctl.mar_from_rf = 1'b1;
          nxt = ST_EXEC;
        end else begin
          ctl.done = 1'b1;
          nxt = ST_F_ADDR;
        end
      end
      ST_EXEC: begin
        ctl.mem_rd   = 1'b1;
        ctl.mdr_load = 1'b1;
        ctl.inc_load = 1'b1;
        nxt = ST_WB_DATA;
      end
      ST_WB_DATA: begin
        ctl.rf_we = 1'b1;
        nxt = ST_WB_BASE;
      end
      ST_WB_BASE: begin
        ctl.rf_we     = 1'b1;
        ctl.wsel_base = 1'b1;
        ctl.done      = 1'b1;
        nxt = ST_F_ADDR;
      end
      default: nxt = ST_F_ADDR;
    endcase
  end
endmodule

// File: rtl/fls_datapath.sv
module fls_datapath
  import fls_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RAW      = 5,
  parameter int BASE_LSB = 21,
  parameter int DEST_LSB = 16,
  parameter int STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_ctl_t        ctl,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] rf_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [RAW-1:0]  rf_raddr,
  output logic [RAW-1:0]  rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic [XLEN-1:0] ir_word,
  output logic [XLEN-1:0] pc_value
);
  logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q, inc_q;
  logic [XLEN-1:0] pc_plus, mar_plus;
  logic [RAW-1:0]  base_idx, dest_idx;

  fls_step #(.W(XLEN), .STEP(STEP)) u_pc_step  (.a(pc_q),  .y(pc_plus));
  fls_step #(.W(XLEN), .STEP(STEP)) u_adr_step (.a(mar_q), .y(mar_plus));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      inc_q <= '0;
    end else begin
      if (ctl.mar_from_pc)      mar_q <= pc_q;
      else if (ctl.mar_from_rf) mar_q <= rf_rdata;
      if (ctl.mdr_load) mdr_q <= mem_rdata;
      if (ctl.pc_load)  pc_q  <= pc_plus;
      if (ctl.ir_load)  ir_q  <= mdr_q;
      if (ctl.inc_load) inc_q <= mar_plus;
    end
  end

  assign base_idx = ir_q[BASE_LSB +: RAW];
  assign dest_idx = ir_q[DEST_LSB +: RAW];
  assign mem_addr = mar_q;
  assign rf_raddr = base_idx;
  assign rf_waddr = ctl.wsel_base ? base_idx : dest_idx;
  assign rf_wdata = ctl.wsel_base ? inc_q : mdr_q;
  assign ir_word  = ir_q;
  assign pc_value = pc_q;
endmodule

// File: rtl/fetch_load_seq.sv
module fetch_load_seq
  import fls_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RAW      = 5,
  parameter int BASE_LSB = 21,
  parameter int DEST_LSB = 16,
  parameter int STEP     = 4
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [RAW-1:0]  rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [RAW-1:0]  rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  input  logic            is_ldpi,
  output logic [XLEN-1:0] ir_word,
  output logic [XLEN-1:0] pc_value,
  output logic [2:0]      state_code,
  output logic            instr_done
);
  seq_state_e state;
  seq_ctl_t   ctl;

  fls_ctrl u_ctrl (
    .clk(clk), .rst(rst), .is_ldpi(is_ldpi), .state(state), .ctl(ctl)
  );

  fls_datapath #(
    .XLEN(XLEN), .RAW(RAW), .BASE_LSB(BASE_LSB), .DEST_LSB(DEST_LSB),
    .STEP(STEP), .RESET_PC('0)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .mem_rdata(mem_rdata), .rf_rdata(rf_rdata),
    .mem_addr(mem_addr), .rf_raddr(rf_raddr), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .ir_word(ir_word), .pc_value(pc_value)
  );

  assign mem_rd     = ctl.mem_rd;
  assign rf_we      = ctl.rf_we;
  assign instr_done = ctl.done;
  assign state_code = state;
endmodule

// File: rtl/fls_seq_chk.sv
module fls_seq_chk #(
  parameter int XLEN = 32,
  parameter int RAW  = 5,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_rd,
  input logic [RAW-1:0]  rf_raddr,
  input logic [XLEN-1:0] rf_rdata,
  input logic            rf_we,
  input logic [RAW-1:0]  rf_waddr,
  input logic [XLEN-1:0] rf_wdata,
  input logic            is_ldpi,
  input logic [XLEN-1:0] pc_value,
  input logic [2:0]      state_code,
  input logic            instr_done
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (state_code == 3'd0 && pc_value == '0 && !mem_rd && !rf_we && !instr_done));

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd0 |=> (state_code == 3'd1 && mem_rd && mem_addr == $past(pc_value)));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd1 |=> (pc_value == $past(pc_value) + XLEN'(STEP) && state_code == 3'd2));

  assert_exec_read_R6: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd3 && is_ldpi) |=> (mem_rd && mem_addr == $past(rf_rdata)));

  assert_base_wb_R7: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd5 |=> (rf_we && rf_waddr == $past(rf_raddr)
                            && rf_wdata == $past(mem_addr) + XLEN'(STEP)));

  assert_one_access_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && rf_we));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> (!instr_done && state_code == 3'd0));
endmodule

bind fetch_load_seq fls_seq_chk #(.XLEN(XLEN), .RAW(RAW), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
  .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .is_ldpi(is_ldpi),
  .pc_value(pc_value), .state_code(state_code), .instr_done(instr_done)
);

// File: tb/fetch_load_seq_bench.sv
module fetch_load_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, rf_rdata, rf_wdata, ir_word, pc_value;
  logic        mem_rd, rf_we, is_ldpi, instr_done;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [2:0]  state_code;

  logic [31:0] mem [0:255];
  logic [31:0] rf  [0:31];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fetch_load_seq u_fetch_load_seq (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .is_ldpi(is_ldpi), .ir_word(ir_word), .pc_value(pc_value),
    .state_code(state_code), .instr_done(instr_done)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  assign rf_rdata  = rf[rf_raddr];
  assign is_ldpi   = (ir_word[31:26] == 6'h23);

  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  function automatic logic [31:0] ldpi(input int base, input int dest);
    return {6'h23, 5'(base), 5'(dest), 16'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model state
  int          m_st;
  logic [31:0] m_pc, m_mar, m_mdr, m_ir, m_inc;
  logic [31:0] m_rf [0:31];
  int          done_cycles[$];

  task automatic compare_cycle(input int cyc);
    string tag;
    bit    e_rd, e_we, e_done, m_ld;
    m_ld = (m_ir[31:26] == 6'h23);
    case (m_st)
      0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
      4: tag = "R6"; default: tag = "R7";
    endcase
    e_rd   = (m_st == 1 || m_st == 4);
    e_we   = (m_st == 5 || m_st == 6);
    e_done = (m_st == 6) || (m_st == 3 && !m_ld);
    chk(state_code == 3'(m_st), tag, 32'(state_code), 32'(m_st));
    chk(pc_value == m_pc, tag, pc_value, m_pc);
    chk(mem_rd == e_rd, "R8", 32'(mem_rd), 32'(e_rd));
    chk(rf_we == e_we, "R8", 32'(rf_we), 32'(e_we));
    chk(instr_done == e_done, "R10", 32'(instr_done), 32'(e_done));
    if (e_rd) chk(mem_addr == m_mar, tag, mem_addr, m_mar);
    if (m_st == 3) chk(ir_word == m_ir, "R4", ir_word, m_ir);
    if (m_st == 5) begin
      chk(rf_waddr == m_ir[20:16], "R7", 32'(rf_waddr), 32'(m_ir[20:16]));
      chk(rf_wdata == m_mdr, "R7", rf_wdata, m_mdr);
    end
    if (m_st == 6) begin
      chk(rf_waddr == m_ir[25:21], "R7", 32'(rf_waddr), 32'(m_ir[25:21]));
      chk(rf_wdata == m_inc, "R7", rf_wdata, m_inc);
    end
    if (e_done) done_cycles.push_back(cyc);
    // advance model to the state after the next edge
    case (m_st)
      0: begin m_mar = m_pc; m_st = 1; end
      1: begin m_mdr = mem[m_mar[9:2]]; m_pc = m_pc + 4; m_st = 2; end
      2: begin m_ir = m_mdr; m_st = 3; end
      3: begin
        if (m_ld) begin m_mar = m_rf[m_ir[25:21]]; m_st = 4; end
        else m_st = 0;
      end
      4: begin m_mdr = mem[m_mar[9:2]]; m_inc = m_mar + 4; m_st = 5; end
      5: begin m_rf[m_ir[20:16]] = m_mdr; m_st = 6; end
      default: begin m_rf[m_ir[25:21]] = m_inc; m_st = 0; end
    endcase
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) begin rf[i] = 32'h0; m_rf[i] = 32'h0; end
    mem[0] = ldpi(1, 3);   // load R3 from R1, R1 += 4
    mem[1] = 32'h0;        // non-load word
    mem[2] = ldpi(2, 2);   // base == destination
    mem[3] = ldpi(1, 4);   // reuse incremented R1
    mem[32'h100 >> 2] = 32'hAAAA_0001;
    mem[32'h104 >> 2] = 32'hBBBB_0002;
    mem[32'h200 >> 2] = 32'hCCCC_0003;
    rf[1] = 32'h100; m_rf[1] = 32'h100;
    rf[2] = 32'h200; m_rf[2] = 32'h200;
    m_st = 0; m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_inc = 0;

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(state_code == 3'd0, "R1", 32'(state_code), 0);
    chk(pc_value == 32'h0, "R1", pc_value, 0);
    chk(!mem_rd && !rf_we && !instr_done, "R1",
        {29'h0, mem_rd, rf_we, instr_done}, 0);
    rst = 1'b0;

    for (int c = 0; c < 30; c++) begin
      compare_cycle(c);
      @(negedge clk);
    end

    // completion timing: load 7 cycles, non-load 4 cycles
    chk(done_cycles.size() >= 4, "R10", 32'(done_cycles.size()), 4);
    if (done_cycles.size() >= 4) begin
      chk(done_cycles[0] == 6,  "R7", 32'(done_cycles[0]), 6);
      chk(done_cycles[1] == 10, "R5", 32'(done_cycles[1]), 10);
      chk(done_cycles[2] == 17, "R7", 32'(done_cycles[2]), 17);
      chk(done_cycles[3] == 24, "R7", 32'(done_cycles[3]), 24);
    end
    chk(rf[3] == 32'hAAAA_0001, "R7", rf[3], 32'hAAAA_0001);
    chk(rf[4] == 32'hBBBB_0002, "R6", rf[4], 32'hBBBB_0002);
    chk(rf[1] == 32'h108, "R7", rf[1], 32'h108);
    chk(rf[2] == 32'h204, "R9", rf[2], 32'h204);

    // reset in the middle of an instruction
    while (state_code != 3'd4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(state_code == 3'd0, "R1", 32'(state_code), 0);
    chk(pc_value == 32'h0, "R1", pc_value, 0);
    chk(!mem_rd && !rf_we, "R1", {30'h0, mem_rd, rf_we}, 0);
    rst = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule